// File: doc/BRIEF.md
# Shared RAM Ownership Arbiter

This block decides, cycle by cycle, whether a shared RAM is driven by the processor port or by a slave bus interface port. A three-state machine holds the current owner: nobody, the processor, or the slave interface. Once the processor wins the RAM it keeps it for a programmable minimum number of cycles. The processor keeps it for that time even when it issues no accesses.

Each port has its own pending timer. A requester that waits longer than its programmed limit takes the RAM away from the other side without waiting for that side to finish. Three 8-bit thresholds set the behaviour: the minimum processor window, the slave pending limit and the processor pending limit. Each port drives a request and an access-complete strobe and receives one registered grant.

Top module: `ram_owner_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both grants are low and the RAM is free.
- R2: When the RAM is free and `cpu_req` is high at a clock edge, `cpu_grant` is high after that edge. This holds even if `slv_req` is also high, and in that case `slv_grant` stays low.
- R3: When the RAM is free, `slv_req` is high and `cpu_req` is low at a clock edge, `slv_grant` is high after that edge.
- R4: The dwell count is 0 in the first cycle after the processor is granted and rises by one each cycle. The processor gives the RAM back (both grants low after the edge) at an edge where `cpu_done` is high and the dwell count is strictly greater than `min_own_i`.
- R5: The slave pending count is 0 in the first cycle that `slv_req` is high and ungranted, and rises by one each cycle. While the processor owns the RAM, an edge where dwell > `min_own_i`, `slv_req` is high and the slave pending count > `slv_lim_i` hands the RAM straight to the slave. This hand-over wins over a simultaneous processor release.
- R6: The processor pending count is measured the same way as the slave's. While the slave owns the RAM, an edge where `cpu_req` is high and the processor pending count > `cpu_lim_i` hands the RAM straight to the processor. This hand-over wins over a simultaneous `slv_done`.
- R7: While the slave owns the RAM and no processor hand-over applies, an edge with `slv_done` high frees the RAM.
- R8: While the processor owns the RAM and dwell ≤ `min_own_i`, `slv_grant` stays low whatever the slave requests, even when `cpu_req` and `cpu_done` are both low.
- R9: The dwell and pending counters saturate at their all-ones value (one bit wider than the thresholds) and never wrap. After an ownership lasting longer than the counter range, a release with `min_own_i` = 255 still happens on the first `cpu_done`.
- R10: The grants come from flip-flops, change only at clock edges, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor wants the RAM |
| cpu_done | input | 1 | Processor access has completed |
| slv_req | input | 1 | Slave interface wants the RAM |
| slv_done | input | 1 | Slave access has completed |
| min_own_i | input | 8 | Minimum processor ownership threshold |
| slv_lim_i | input | 8 | Slave pending limit |
| cpu_lim_i | input | 8 | Processor pending limit |
| cpu_grant | output | 1 | Processor owns the RAM |
| slv_grant | output | 1 | Slave interface owns the RAM |

## Verification
The bench builds the block with its default 8-bit thresholds, so each counter is 9 bits wide and saturates at 511. Small threshold values of 0 to 5 bring every transition edge within a few cycles, so each hand-over can be checked at its exact cycle. This covers the priority between a forced hand-over and a normal release in both owner states. A threshold of 255 with an ownership of 600 cycles drives the dwell counter past its range, where a wrap would show up as a missing release.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;

  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_SLV  = 2'd2
  } owner_t;

  // strict greater-than between a count and a threshold
  function automatic logic exceeds(input int unsigned count, input int unsigned thr);
    return count > thr;
  endfunction

  // ownership transition rule; hand-overs outrank normal releases
  function automatic owner_t next_owner(
    input owner_t cur,
    input logic   cpu_req,
    input logic   slv_req,
    input logic   cpu_release,
    input logic   slv_take,
    input logic   cpu_take,
    input logic   slv_done
  );
    owner_t nxt;
    unique case (cur)
      OWN_FREE: nxt = cpu_req ? OWN_CPU : (slv_req ? OWN_SLV : OWN_FREE);
      OWN_CPU:  nxt = slv_take ? OWN_SLV : (cpu_release ? OWN_FREE : OWN_CPU);
      OWN_SLV:  nxt = cpu_take ? OWN_CPU : (slv_done ? OWN_FREE : OWN_SLV);
      default:  nxt = OWN_FREE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/ram_arb_sat_cnt.sv
module ram_arb_sat_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic at_top;
  assign at_top = (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (!at_top) count <= count + ONE;
  end

  // R9: a full counter stays full unless cleared
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !clear) |=> (count == TOP));

endmodule

// File: rtl/ram_arb_fsm.sv
module ram_arb_fsm
  import ram_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cpu_req,
  input  logic   slv_req,
  input  logic   cpu_release,
  input  logic   slv_take,
  input  logic   cpu_take,
  input  logic   slv_done,
  output owner_t owner,
  output owner_t owner_nxt
);
  assign owner_nxt = next_owner(owner, cpu_req, slv_req, cpu_release,
                                slv_take, cpu_take, slv_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_FREE;
    else        owner <= owner_nxt;
  end

  // R6: a forced processor hand-over always lands in processor ownership
  assert_cpu_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_SLV && cpu_take) |=> (owner == OWN_CPU));

  // R7: slave completion without a hand-over frees the RAM
  assert_slv_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_SLV && !cpu_take && slv_done) |=> (owner == OWN_FREE));

endmodule

// File: rtl/ram_owner_arb.sv
module ram_owner_arb
  import ram_arb_pkg::*;
#(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_done,
  input  logic             slv_req,
  input  logic             slv_done,
  input  logic [THR_W-1:0] min_own_i,
  input  logic [THR_W-1:0] slv_lim_i,
  input  logic [THR_W-1:0] cpu_lim_i,
  output logic             cpu_grant,
  output logic             slv_grant
);
  localparam int CNT_W = THR_W + 1;
  localparam int NPORT = 2;   // index 0: processor, 1: slave

  owner_t             owner, owner_nxt;
  logic [CNT_W-1:0]   dwell;
  logic [CNT_W-1:0]   pend [NPORT];
  logic [NPORT-1:0]   req_v, gnt_v;
  logic [THR_W-1:0]   lim_v [NPORT];
  logic [NPORT-1:0]   overdue_v;

  // named events used by the next-state rule and the assertions
  logic moving, window_open, cpu_release, slv_take, cpu_take;

  assign cpu_grant = (owner == OWN_CPU);
  assign slv_grant = (owner == OWN_SLV);

  assign req_v = {slv_req, cpu_req};
  assign gnt_v = {slv_grant, cpu_grant};
  assign lim_v[0] = cpu_lim_i;
  assign lim_v[1] = slv_lim_i;

  assign moving = (owner_nxt != owner);

  ram_arb_sat_cnt #(.W(CNT_W)) u_dwell (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (moving),
    .count (dwell)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_pend
    logic idle;
    assign idle = !req_v[p] || gnt_v[p];

    ram_arb_sat_cnt #(.W(CNT_W)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (idle),
      .count (pend[p])
    );

    assign overdue_v[p] = req_v[p] &&
                          exceeds(32'(pend[p]), 32'(lim_v[p]));
  end

  assign window_open = exceeds(32'(dwell), 32'(min_own_i));
  assign cpu_release = cpu_done && window_open;
  assign slv_take    = window_open && overdue_v[1];
  assign cpu_take    = overdue_v[0];

  ram_arb_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .slv_req     (slv_req),
    .cpu_release (cpu_release),
    .slv_take    (slv_take),
    .cpu_take    (cpu_take),
    .slv_done    (slv_done),
    .owner       (owner),
    .owner_nxt   (owner_nxt)
  );

  // R10: grants never overlap
  assert_grant_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_grant && slv_grant));

  // R2: processor wins a free RAM
  assert_free_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_grant && !slv_grant && cpu_req) |=> cpu_grant);

  // R8: the slave is held off while the processor window is still closed
  assert_cpu_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_grant && !window_open) |=> !slv_grant);

  // R5: an overdue slave takes the RAM once the window has opened
  assert_slv_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_grant && slv_take) |=> slv_grant);

endmodule

// File: tb/ram_owner_arb_tb.sv
`timescale 1ns/1ps
module ram_owner_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req = 1'b0, cpu_done = 1'b0, slv_req = 1'b0, slv_done = 1'b0;
  logic [7:0] min_own_i = '0, slv_lim_i = '0, cpu_lim_i = '0;
  logic       cpu_grant, slv_grant;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  ram_owner_arb u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_done(cpu_done),
    .slv_req(slv_req), .slv_done(slv_done),
    .min_own_i(min_own_i), .slv_lim_i(slv_lim_i), .cpu_lim_i(cpu_lim_i),
    .cpu_grant(cpu_grant), .slv_grant(slv_grant)
  );

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp_c, input logic exp_s);
    checks++;
    if (cpu_grant !== exp_c || slv_grant !== exp_s) begin
      errors++;
      $display("FAIL %s: cpu_grant/slv_grant actual %b%b expected %b%b",
               req, cpu_grant, slv_grant, exp_c, exp_s);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // bring the arbiter back to free between scenarios
  task automatic idle_bus();
    cpu_req = 0; slv_req = 0; cpu_done = 1; slv_done = 1; min_own_i = 0;
    cyc(4);
    cpu_done = 0; slv_done = 0;
    cyc(1);
  endtask

  task automatic t_reset();
    cyc(3);
    check("R1 during reset", 0, 0);
    rst_n = 1'b1;
    cyc(1);
    check("R1 after reset", 0, 0);
  endtask

  task automatic t_cpu_priority_release();
    min_own_i = 3; cpu_req = 1; slv_req = 1;
    cyc(1);
    check("R2 cpu wins over slave", 1, 0);
    cpu_req = 0; slv_req = 0; cpu_done = 1;
    cyc(4);
    check("R4 held until dwell > min_own", 1, 0);
    cyc(1);
    check("R4 released after dwell > min_own", 0, 0);
    idle_bus();
  endtask

  task automatic t_slave_from_free();
    slv_req = 1;
    cyc(1);
    check("R3 slave granted from free", 0, 1);
    slv_req = 0; slv_done = 1;
    cyc(1);
    check("R7 slave done frees RAM", 0, 0);
    idle_bus();
  endtask

  task automatic t_cpu_window();
    min_own_i = 5; slv_lim_i = 0; cpu_req = 1;
    cyc(1);
    check("R2 cpu granted", 1, 0);
    cpu_req = 0; slv_req = 1;
    cyc(6);
    check("R8 slave held off during idle cpu window", 1, 0);
    cyc(1);
    check("R5 slave takes RAM after window", 0, 1);
    idle_bus();
  endtask

  task automatic t_slave_preempt();
    min_own_i = 0; slv_lim_i = 4; cpu_req = 1;
    cyc(1);
    slv_req = 1;
    cyc(5);
    check("R5 slave not yet overdue", 1, 0);
    cpu_done = 1;
    cyc(1);
    check("R5 hand-over beats cpu release", 0, 1);
    idle_bus();
  endtask

  task automatic t_cpu_preempt();
    cpu_lim_i = 3; slv_req = 1;
    cyc(1);
    check("R3 slave granted", 0, 1);
    cpu_req = 1;
    cyc(4);
    check("R6 cpu not yet overdue", 0, 1);
    slv_done = 1;
    cyc(1);
    check("R6 hand-over beats slave done", 1, 0);
    idle_bus();
  endtask

  task automatic t_saturate();
    min_own_i = 8'd255; cpu_req = 1;
    cyc(1);
    check("R10 cpu granted alone", 1, 0);
    cyc(599);
    check("R9 long ownership kept", 1, 0);
    cpu_done = 1;
    cyc(1);
    check("R9 saturated dwell still releases", 0, 0);
    idle_bus();
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_cpu_priority_release();
    t_slave_from_free();
    t_cpu_window();
    t_slave_preempt();
    t_cpu_preempt();
    t_saturate();
    finish_run();
  end

endmodule